// File: doc/BRIEF.md
# Multi-Mode Self-Test Register

This block is a bank of flip-flops that can take on one of four roles, chosen by a two-bit mode input. It can be an ordinary pipeline register or a serial shift chain. It can clear itself. It can also act as a linear-feedback register, which serves two purposes. With its parallel inputs held at zero it generates a pseudo-random pattern. With the outputs of a logic block applied to its parallel inputs it compacts that response stream into a multi-input signature. A chip places such a register between logic clouds. A test pass then seeds it, runs it for a number of cycles and shifts the resulting signature out serially for comparison.

The width is a parameter from 2 to 16. The feedback taps are chosen at elaboration time from a built-in table of maximal-length polynomials. For the default width of 3 the generator runs through all seven nonzero states. Every mode takes effect on the next rising clock edge. There is also a synchronous active-high reset.

Top module: `selftest_register`

## Requirements
- R1: While `rst` is high at a rising edge, `q` becomes all zeros on that edge, whatever `mode` is.
- R2: Mode 2'b11 (load): at each edge `q` takes the value of `d`.
- R3: Mode 2'b00 (shift): at each edge `q[0]` takes `si` and `q[i]` takes the old `q[i-1]`, so bits move from `si` toward `so`.
- R4: Mode 2'b10 (clear): at each edge `q` becomes all zeros.
- R5: Mode 2'b01 (self-test) with `d` = 0 and width 3: starting from 3'b111, `q` steps through 110, 101, 010, 100, 001, 011 and then returns to 111, giving a period of 7.
- R6: Mode 2'b01 with any `d`: the next `q` is {old `q[W-2:0]`, feedback} XOR `d`. The feedback is the XOR of the tapped bits of the old `q`; for width 3 it is `q[2]` XOR `q[0]`. A stream of `d` words therefore leaves a signature in `q`.
- R7: Mode 2'b01 with `d` = 0 holds an all-zero `q` at zero (the lock-up state). Any nonzero `q` stays nonzero under the same condition.
- R8: `so` always equals `q[W-1]`, the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, clears the register |
| mode | input | 2 | 00 shift, 01 self-test, 10 clear, 11 load |
| d | input | W | Parallel data input, also the response input in self-test |
| si | input | 1 | Serial input into stage 0 |
| q | output | W | Parallel register state |
| so | output | 1 | Serial output, the last stage |

## Verification
The bench seeds 111 and checks every state of the seven-step cycle, including the wrap back to the seed. A wrong tap or a wrong shift direction would break that cycle early or give a shorter period. It scans a pattern in and out and watches `so` on each bit. A stage order that is reversed or off by one would show up as a permuted or delayed bit stream. It then drives a response stream of eight words and compares the signature after every word, which catches a missing XOR with `d` or a dropped feedback term. The bench also checks that clear and reset win from a nonzero state, including a reset asserted in the middle of a self-test run. Finally it checks that an all-zero state stays locked.

// File: rtl/str_pkg.sv
package str_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT    = 2'b00,
    MODE_SELFTEST = 2'b01,
    MODE_CLEAR    = 2'b10,
    MODE_LOAD     = 2'b11
  } str_mode_e;

  localparam int MIN_WIDTH = 2;
  localparam int MAX_WIDTH = 16;

  // Tap mask for a shift-toward-MSB register whose new stage 0 is the XOR
  // of the masked bits; bit k set means stage k feeds back. Every entry is
  // a maximal-length polynomial for its width.
  function automatic logic [MAX_WIDTH-1:0] tap_mask(input int width);
    logic [MAX_WIDTH-1:0] m;
    case (width)
      2:       m = 16'h0003;
      3:       m = 16'h0005;
      4:       m = 16'h000C;
      5:       m = 16'h0014;
      6:       m = 16'h0030;
      7:       m = 16'h0060;
      8:       m = 16'h00B8;
      9:       m = 16'h0110;
      10:      m = 16'h0240;
      11:      m = 16'h0500;
      12:      m = 16'h0829;
      13:      m = 16'h100D;
      14:      m = 16'h2015;
      15:      m = 16'h6000;
      16:      m = 16'hD008;
      default: m = 16'h0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/str_feedback.sv
module str_feedback #(
  parameter int W = 3
) (
  input  logic [W-1:0] state,
  output logic         fb
);
  import str_pkg::*;

  localparam logic [MAX_WIDTH-1:0] FULL_MASK = tap_mask(W);
  localparam logic [W-1:0]         MASK      = FULL_MASK[W-1:0];

  always_comb begin
    fb = ^(state & MASK);
  end

endmodule

// File: rtl/str_cell.sv
module str_cell (
  input  logic              clk,
  input  logic              rst,
  input  str_pkg::str_mode_e mode,
  input  logic              d_bit,
  input  logic              chain_in,
  input  logic              test_in,
  output logic              q_bit
);
  import str_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_bit <= 1'b0;
    end else begin
      case (mode)
        MODE_SHIFT:    q_bit <= chain_in;
        MODE_SELFTEST: q_bit <= test_in ^ d_bit;
        MODE_CLEAR:    q_bit <= 1'b0;
        MODE_LOAD:     q_bit <= d_bit;
        default:       q_bit <= q_bit;
      endcase
    end
  end

endmodule

// File: rtl/selftest_register.sv
module selftest_register #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic [W-1:0] d,
  input  logic         si,
  output logic [W-1:0] q,
  output logic         so
);
  import str_pkg::*;

  str_mode_e mode_e;
  logic      fb;

  assign mode_e = str_mode_e'(mode);

  str_feedback #(.W(W)) u_fb (
    .state (q),
    .fb    (fb)
  );

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_head
      str_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_e),
        .d_bit    (d[i]),
        .chain_in (si),
        .test_in  (fb),
        .q_bit    (q[i])
      );
    end else begin : g_body
      str_cell u_cell (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_e),
        .d_bit    (d[i]),
        .chain_in (q[i-1]),
        .test_in  (q[i-1]),
        .q_bit    (q[i])
      );
    end
  end

  assign so = q[W-1];

  // R1: reset wins over every mode
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (q == '0));

  // R2: load mode copies d
  a_r2_load_copies: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b11) |=> (q == $past(d)));

  // R3: shift mode moves bits from si toward so
  a_r3_shift_order: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00) |=> (q == {$past(q[W-2:0]), $past(si)}));

  // R4: clear mode zeroes the register
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10) |=> (q == '0));

  // R7: lock-up state persists, nonzero state never collapses
  a_r7_lockup_holds: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && d == '0 && q == '0) |=> (q == '0));

  a_r7_nonzero_stays: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b01 && d == '0 && q != '0) |=> (q != '0));

endmodule

// File: tb/selftest_register_bench.sv
module selftest_register_bench;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode;
  logic [W-1:0] d;
  logic         si;
  logic [W-1:0] q;
  logic         so;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;
  logic [2:0] model;

  always #4 clk = ~clk;

  selftest_register #(.W(W)) u_selftest_register (
    .clk(clk), .rst(rst), .mode(mode), .d(d), .si(si), .q(q), .so(so)
  );

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, update reference at posedge, compare after.
  task automatic step(input logic r, input logic [1:0] m, input logic [2:0] dv,
                      input logic s, input string tag);
    @(negedge clk);
    rst = r; mode = m; d = dv; si = s;
    @(posedge clk);
    if (r) model = 3'b000;
    else begin
      case (m)
        2'b00: model = {model[1:0], s};
        2'b01: model = {model[1:0], model[2] ^ model[0]} ^ dv;
        2'b10: model = 3'b000;
        default: model = dv;
      endcase
    end
    #2;
    check(tag, q, model);
    check("R8 so", {2'b00, so}, {2'b00, model[2]});
  endtask

  initial begin
    logic [2:0] cyc [7];
    logic [2:0] resp [8];
    cyc  = '{3'b110, 3'b101, 3'b010, 3'b100, 3'b001, 3'b011, 3'b111};
    resp = '{3'b101, 3'b011, 3'b110, 3'b001, 3'b111, 3'b000, 3'b100, 3'b010};
    rst = 1'b1; mode = 2'b11; d = 3'b000; si = 1'b0; model = 3'b000;

    // R1: reset state
    step(1'b1, 2'b11, 3'b101, 1'b1, "R1 reset");
    step(1'b1, 2'b01, 3'b111, 1'b1, "R1 reset");

    // R2: parallel load of several words
    step(1'b0, 2'b11, 3'b010, 1'b0, "R2 load");
    step(1'b0, 2'b11, 3'b110, 1'b0, "R2 load");
    step(1'b0, 2'b11, 3'b111, 1'b0, "R2 load seed");

    // R5: seven-step generator cycle from 111
    for (int i = 0; i < 7; i++) begin
      step(1'b0, 2'b01, 3'b000, 1'b0, "R5 generator");
      check("R5 sequence", q, cyc[i]);
    end
    step(1'b0, 2'b01, 3'b000, 1'b0, "R5 second lap");
    check("R5 second lap", q, 3'b110);

    // R4: clear from nonzero
    step(1'b0, 2'b10, 3'b111, 1'b1, "R4 clear");

    // R3: shift in 1,0,1 then out with zeros, watching so
    step(1'b0, 2'b00, 3'b000, 1'b1, "R3 shift in");
    step(1'b0, 2'b00, 3'b111, 1'b0, "R3 shift in");
    step(1'b0, 2'b00, 3'b000, 1'b1, "R3 shift in");
    check("R3 pattern", q, 3'b101);
    step(1'b0, 2'b00, 3'b000, 1'b0, "R3 shift out");
    check("R3 so bit", {2'b00, so}, 3'b000);
    step(1'b0, 2'b00, 3'b000, 1'b0, "R3 shift out");
    check("R3 so bit", {2'b00, so}, 3'b001);
    step(1'b0, 2'b00, 3'b000, 1'b0, "R3 shift out");
    check("R3 drained", q, 3'b000);

    // R7: all-zero state locks under self-test with d = 0
    for (int i = 0; i < 4; i++) step(1'b0, 2'b01, 3'b000, 1'b1, "R7 lockup");
    check("R7 still zero", q, 3'b000);

    // R6: signature of a response stream from a zero start
    step(1'b0, 2'b10, 3'b000, 1'b0, "R4 clear before signature");
    for (int i = 0; i < 8; i++) step(1'b0, 2'b01, resp[i], 1'b0, "R6 signature");

    // R1: reset during self-test from a nonzero state
    step(1'b0, 2'b11, 3'b111, 1'b0, "R2 reseed");
    step(1'b0, 2'b01, 3'b000, 1'b0, "R5 run");
    step(1'b1, 2'b01, 3'b000, 1'b0, "R1 reset mid-run");
    step(1'b0, 2'b01, 3'b000, 1'b0, "R7 after reset");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule